// File: doc/BRIEF.md
# Command Frame Bit Encoder

This block turns a short command, whose check bytes have already been appended upstream, into the serial bit sequence a reader sends to a proximity card. Each output bit lasts one elementary time unit (etu). The modulator supplies a one-cycle enable pulse per etu, and the encoder presents one new bit on each pulse.

A frame has a fixed layout. It opens with a long high run so the receiver can settle on a reference level, followed by a low start-of-frame marker. Every byte is preceded by high guard bits and a low start bit, and its data bits follow least significant bit first. The frame closes with a high bit, a low end-of-frame marker and a long high trailer. The trailer lets the last character clear the air before the link is turned around.

A controller pulses `start_i` with the byte count. Command bytes then arrive over a ready/valid handshake, and one byte may be taken ahead of the byte being sent. If the next byte is late, the encoder keeps sending guard bits rather than breaking the character framing.

Top module: `cmd_frame_bit_encoder`

## Requirements
- R1: After reset, and whenever no frame is in progress, `busy_o`, `done_o` and `byte_ready_o` are 0 and `bit_o` is 1.
- R2: A frame begins with 40 high bits followed by 10 low bits.
- R3: Each byte is sent as 2 high guard bits, then 1 low start bit, then its 8 data bits with bit 0 sent first.
- R4: After the last byte the encoder sends 1 high bit, then 10 low bits, then 8 high bits, then 24 more high bits, and then stops. A frame with N bytes and no stalls is 93 + 11·N bits long.
- R5: `bit_o` takes a new value only at a clock edge where `etu_en_i` is high during a frame, and holds its value otherwise.
- R6: A start with length 0 still produces the full 93-bit frame (preamble, start marker, end marker and trailer) and requests no byte.
- R7: `busy_o` rises on the edge that accepts a start and falls on the edge that emits the final trailer bit. `done_o` is high for exactly the one cycle after that edge.
- R8: A start request while `busy_o` is high is ignored, and the frame in progress continues unchanged.
- R9: Exactly the requested number of bytes is accepted, one per cycle in which `byte_valid_i` and `byte_ready_o` are both high. `byte_ready_o` is high only during a frame, only while a byte is still owed, and only while the one-byte holding stage is empty.
- R10: If the next byte has not been accepted when its guard bits are complete, further high guard bits are sent, one per etu, until the byte is available. The start bit follows the first guard bit emitted after acceptance.
- R11: The length is sampled only on the accepting start edge. Later changes on `len_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted when idle |
| len_i | input | LEN_W | Number of command bytes in the frame |
| byte_valid_i | input | 1 | Command byte offered |
| byte_data_i | input | BYTE_W | Command byte |
| byte_ready_o | output | 1 | Encoder takes the offered byte this cycle |
| etu_en_i | input | 1 | One pulse per bit period |
| bit_o | output | 1 | Serial frame bit toward the modulator |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse after the final bit |

## Verification
The byte stream is tried with several pattern types. Alternating and single-bit patterns expose bit-order and shift-direction errors. All-zero and all-one bytes separate data bits from the neighbouring start and guard levels. Random bytes of random length catch miscounted byte totals. A zero-length frame isolates the fixed framing from the per-byte path. A withheld first byte distinguishes a guard extension from a dropped or early start bit. Back-to-back etu pulses test the prefetch margin. A repeated start and a changing length input during a frame show that the sampled length, not the live one, drives the frame.

// File: rtl/feb_pkg.sv
package feb_pkg;

   typedef enum logic [3:0] {
      PH_IDLE,
      PH_PRE,
      PH_SOF,
      PH_GUARD,
      PH_START,
      PH_DATA,
      PH_EGAP,
      PH_ELOW,
      PH_EHIGH,
      PH_TAIL
   } feb_phase_e;

endpackage

// File: rtl/feb_byte_stage.sv
module feb_byte_stage #(
   parameter int BYTE_W    = 8,
   parameter int LEN_W     = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy_i,
   input  logic              frame_start_i,
   input  logic [LEN_W-1:0]  frame_len_i,
   input  logic              in_valid_i,
   input  logic [BYTE_W-1:0] in_data_i,
   output logic              in_ready_o,
   input  logic              load_i,
   input  logic              shift_i,
   output logic              have_byte_o,
   output logic              data_bit_o
);

   logic [LEN_W-1:0]  fetch_left_q;
   logic [BYTE_W-1:0] hold_q;
   logic              hold_full_q;
   logic [BYTE_W-1:0] shreg_q;
   logic [BYTE_W-1:0] shreg_shifted;
   logic              accept;

   assign in_ready_o  = busy_i && !hold_full_q && (fetch_left_q != '0);
   assign accept      = in_valid_i && in_ready_o;
   assign have_byte_o = hold_full_q;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign data_bit_o    = shreg_q[0];
         assign shreg_shifted = {1'b0, shreg_q[BYTE_W-1:1]};
      end else begin : g_msb
         assign data_bit_o    = shreg_q[BYTE_W-1];
         assign shreg_shifted = {shreg_q[BYTE_W-2:0], 1'b0};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fetch_left_q <= '0;
         hold_q       <= '0;
         hold_full_q  <= 1'b0;
         shreg_q      <= '0;
      end else if (frame_start_i) begin
         fetch_left_q <= frame_len_i;
         hold_full_q  <= 1'b0;
      end else begin
         if (accept) begin
            hold_q       <= in_data_i;
            hold_full_q  <= 1'b1;
            fetch_left_q <= fetch_left_q - 1'b1;
         end else if (load_i) begin
            hold_full_q <= 1'b0;
         end
         if (load_i) begin
            shreg_q <= hold_q;
         end else if (shift_i) begin
            shreg_shifted_hold: shreg_q <= shreg_shifted;
         end
      end
   end

   // R9: the sequencer consumes a byte only when one is held
   assert_load_has_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> hold_full_q);

   // R9: an accepted byte is held on the next cycle
   assert_accept_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && in_ready_o && !frame_start_i) |=> hold_full_q);

endmodule

// File: rtl/feb_sequencer.sv
module feb_sequencer
   import feb_pkg::*;
#(
   parameter int BYTE_W        = 8,
   parameter int LEN_W         = 8,
   parameter int PREAMBLE_BITS = 40,
   parameter int SOF_BITS      = 10,
   parameter int GUARD_BITS    = 2,
   parameter int EOF_LOW_BITS  = 10,
   parameter int EOF_HIGH_BITS = 8,
   parameter int TAIL_BITS     = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic             etu_en_i,
   input  logic             have_byte_i,
   input  logic             data_bit_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             bit_o,
   output logic             frame_start_o,
   output logic             load_o,
   output logic             shift_o
);

   localparam int M1      = (PREAMBLE_BITS > SOF_BITS) ? PREAMBLE_BITS : SOF_BITS;
   localparam int M2      = (M1 > GUARD_BITS) ? M1 : GUARD_BITS;
   localparam int M3      = (M2 > EOF_LOW_BITS) ? M2 : EOF_LOW_BITS;
   localparam int M4      = (M3 > EOF_HIGH_BITS) ? M3 : EOF_HIGH_BITS;
   localparam int M5      = (M4 > TAIL_BITS) ? M4 : TAIL_BITS;
   localparam int SEG_MAX = (M5 > BYTE_W) ? M5 : BYTE_W;
   localparam int CNT_W   = $clog2(SEG_MAX + 1);

   localparam logic [CNT_W-1:0] PRE_LAST   = CNT_W'(PREAMBLE_BITS - 1);
   localparam logic [CNT_W-1:0] SOF_LAST   = CNT_W'(SOF_BITS - 1);
   localparam logic [CNT_W-1:0] GUARD_LAST = CNT_W'(GUARD_BITS - 1);
   localparam logic [CNT_W-1:0] BYTE_LAST  = CNT_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] ELOW_LAST  = CNT_W'(EOF_LOW_BITS - 1);
   localparam logic [CNT_W-1:0] EHIGH_LAST = CNT_W'(EOF_HIGH_BITS - 1);
   localparam logic [CNT_W-1:0] TAIL_LAST  = CNT_W'(TAIL_BITS - 1);

   feb_phase_e       ph_q, ph_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [LEN_W-1:0] left_q, left_d;
   logic             bit_q, bit_d;
   logic             done_q, done_d;
   logic             adv;

   assign busy_o        = (ph_q != PH_IDLE);
   assign frame_start_o = start_req_i && !busy_o;
   assign adv           = etu_en_i && busy_o;
   assign bit_o         = bit_q;
   assign done_o        = done_q;

   always_comb begin
      ph_d    = ph_q;
      cnt_d   = cnt_q;
      left_d  = left_q;
      bit_d   = bit_q;
      done_d  = 1'b0;
      load_o  = 1'b0;
      shift_o = 1'b0;
      if (frame_start_o) begin
         ph_d   = PH_PRE;
         cnt_d  = '0;
         left_d = len_i;
      end else if (adv) begin
         case (ph_q)
            PH_PRE: begin
               bit_d = 1'b1;
               if (cnt_q == PRE_LAST) begin
                  ph_d  = PH_SOF;
                  cnt_d = '0;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            PH_SOF: begin
               bit_d = 1'b0;
               if (cnt_q == SOF_LAST) begin
                  ph_d  = (left_q != '0) ? PH_GUARD : PH_EGAP;
                  cnt_d = '0;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            PH_GUARD: begin
               bit_d = 1'b1;
               if (cnt_q >= GUARD_LAST) begin
                  if (have_byte_i) begin
                     ph_d  = PH_START;
                     cnt_d = '0;
                  end
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            PH_START: begin
               bit_d  = 1'b0;
               load_o = 1'b1;
               ph_d   = PH_DATA;
               cnt_d  = '0;
            end
            PH_DATA: begin
               bit_d   = data_bit_i;
               shift_o = 1'b1;
               if (cnt_q == BYTE_LAST) begin
                  cnt_d  = '0;
                  left_d = left_q - 1'b1;
                  ph_d   = (left_q == LEN_W'(1)) ? PH_EGAP : PH_GUARD;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            PH_EGAP: begin
               bit_d = 1'b1;
               ph_d  = PH_ELOW;
               cnt_d = '0;
            end
            PH_ELOW: begin
               bit_d = 1'b0;
               if (cnt_q == ELOW_LAST) begin
                  ph_d  = PH_EHIGH;
                  cnt_d = '0;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            PH_EHIGH: begin
               bit_d = 1'b1;
               if (cnt_q == EHIGH_LAST) begin
                  ph_d  = PH_TAIL;
                  cnt_d = '0;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            PH_TAIL: begin
               bit_d = 1'b1;
               if (cnt_q == TAIL_LAST) begin
                  ph_d   = PH_IDLE;
                  cnt_d  = '0;
                  done_d = 1'b1;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            default: begin
               ph_d  = PH_IDLE;
               bit_d = 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         left_q <= '0;
         bit_q  <= 1'b1;
         done_q <= 1'b0;
      end else begin
         ph_q   <= ph_d;
         cnt_q  <= cnt_d;
         left_q <= left_d;
         bit_q  <= bit_d;
         done_q <= done_d;
      end
   end

   // R1: line rests high outside a frame
   assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> bit_o);

   // R5: no etu pulse, no change on the line
   assert_hold_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !etu_en_i |=> $stable(bit_o));

   // R7: done is a single-cycle pulse
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7: done coincides with the end of busy
   assert_done_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $fell(busy_o));

   // R2: every bit sent during the start marker is low
   assert_sof_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && ph_q == PH_SOF) |=> !bit_o);

   // R8: a start while busy does not restart the preamble
   assert_restart_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_req_i && ph_q != PH_PRE && !(adv && ph_q == PH_TAIL)) |=> ph_q != PH_PRE);

endmodule

// File: rtl/cmd_frame_bit_encoder.sv
module cmd_frame_bit_encoder #(
   parameter int BYTE_W        = 8,
   parameter int LEN_W         = 8,
   parameter bit LSB_FIRST     = 1'b1,
   parameter int PREAMBLE_BITS = 40,
   parameter int SOF_BITS      = 10,
   parameter int GUARD_BITS    = 2,
   parameter int EOF_LOW_BITS  = 10,
   parameter int EOF_HIGH_BITS = 8,
   parameter int TAIL_BITS     = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic              byte_valid_i,
   input  logic [BYTE_W-1:0] byte_data_i,
   output logic              byte_ready_o,
   input  logic              etu_en_i,
   output logic              bit_o,
   output logic              busy_o,
   output logic              done_o
);

   generate
      if (BYTE_W < 2) begin : g_bad_byte_w
         $error("BYTE_W must be at least 2");
      end
      if (LEN_W < 1) begin : g_bad_len_w
         $error("LEN_W must be at least 1");
      end
      if (PREAMBLE_BITS < 1 || SOF_BITS < 1 || GUARD_BITS < 1) begin : g_bad_head
         $error("preamble, start marker and guard lengths must be at least 1");
      end
      if (EOF_LOW_BITS < 1 || EOF_HIGH_BITS < 1 || TAIL_BITS < 1) begin : g_bad_tail
         $error("end marker and trailer lengths must be at least 1");
      end
   endgenerate

   logic frame_start;
   logic load;
   logic shift;
   logic have_byte;
   logic data_bit;

   feb_sequencer #(
      .BYTE_W        (BYTE_W),
      .LEN_W         (LEN_W),
      .PREAMBLE_BITS (PREAMBLE_BITS),
      .SOF_BITS      (SOF_BITS),
      .GUARD_BITS    (GUARD_BITS),
      .EOF_LOW_BITS  (EOF_LOW_BITS),
      .EOF_HIGH_BITS (EOF_HIGH_BITS),
      .TAIL_BITS     (TAIL_BITS)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_req_i   (start_i),
      .len_i         (len_i),
      .etu_en_i      (etu_en_i),
      .have_byte_i   (have_byte),
      .data_bit_i    (data_bit),
      .busy_o        (busy_o),
      .done_o        (done_o),
      .bit_o         (bit_o),
      .frame_start_o (frame_start),
      .load_o        (load),
      .shift_o       (shift)
   );

   feb_byte_stage #(
      .BYTE_W    (BYTE_W),
      .LEN_W     (LEN_W),
      .LSB_FIRST (LSB_FIRST)
   ) u_bytes (
      .clk           (clk),
      .rst_n         (rst_n),
      .busy_i        (busy_o),
      .frame_start_i (frame_start),
      .frame_len_i   (len_i),
      .in_valid_i    (byte_valid_i),
      .in_data_i     (byte_data_i),
      .in_ready_o    (byte_ready_o),
      .load_i        (load),
      .shift_i       (shift),
      .have_byte_o   (have_byte),
      .data_bit_o    (data_bit)
   );

   // R9: bytes are only requested during a frame
   assert_ready_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
      byte_ready_o |-> busy_o);

endmodule

// File: tb/sim_cmd_frame_bit_encoder.sv
module sim_cmd_frame_bit_encoder;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [7:0] len_i = '0;
   logic       byte_valid_i = 1'b0;
   logic [7:0] byte_data_i = '0;
   logic       byte_ready_o;
   logic       etu_en_i = 1'b0;
   logic       bit_o;
   logic       busy_o;
   logic       done_o;

   int checks = 0;
   int failures = 0;

   logic [7:0] fb [0:15];
   logic       expb [0:511];
   logic       got  [0:511];
   int         exp_n;
   int         got_n;

   always #5 clk = ~clk;

   cmd_frame_bit_encoder u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .len_i        (len_i),
      .byte_valid_i (byte_valid_i),
      .byte_data_i  (byte_data_i),
      .byte_ready_o (byte_ready_o),
      .etu_en_i     (etu_en_i),
      .bit_o        (bit_o),
      .busy_o       (busy_o),
      .done_o       (done_o)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic build_exp(input int len, input int guard0);
      exp_n = 0;
      for (int i = 0; i < 40; i++) begin expb[exp_n] = 1'b1; exp_n++; end
      for (int i = 0; i < 10; i++) begin expb[exp_n] = 1'b0; exp_n++; end
      for (int k = 0; k < len; k++) begin
         int g;
         g = (k == 0) ? guard0 : 2;
         for (int i = 0; i < g; i++) begin expb[exp_n] = 1'b1; exp_n++; end
         expb[exp_n] = 1'b0; exp_n++;
         for (int i = 0; i < 8; i++) begin expb[exp_n] = fb[k][i]; exp_n++; end
      end
      expb[exp_n] = 1'b1; exp_n++;
      for (int i = 0; i < 10; i++) begin expb[exp_n] = 1'b0; exp_n++; end
      for (int i = 0; i < 32; i++) begin expb[exp_n] = 1'b1; exp_n++; end
   endtask

   task automatic cmp_range(input int lo, input int hi, input string req, input string name);
      int bad_at;
      bad_at = -1;
      for (int i = lo; i < hi; i++) begin
         if (bad_at < 0 && (i >= got_n || got[i] !== expb[i])) bad_at = i;
      end
      if (bad_at < 0) chk(1'b1, req, name, 0, 0);
      else chk(1'b0, req, $sformatf("%s bit %0d", name, bad_at),
               (bad_at < got_n) ? int'(got[bad_at]) : -1, int'(expb[bad_at]));
   endtask

   task automatic run_frame(input int len, input int period, input int stall_at,
                            input int restart_at, input int guard0, input string name);
      int  cyc, acc, dones, busy_bad, stable_bad, ready_bad, div;
      bit  finished, etu_prev, busy_prev, valid_prev, ready_prev, last_bit;
      build_exp(len, guard0);
      @(negedge clk);
      start_i = 1'b1; len_i = 8'(len); etu_en_i = 1'b0; byte_valid_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0; len_i = 8'($urandom_range(0, 255));   // R11: junk after start
      chk(busy_o === 1'b1, "R7", {name, " busy after start"}, int'(busy_o), 1);
      got_n = 0; acc = 0; dones = 0; busy_bad = 0; stable_bad = 0; ready_bad = 0;
      div = 0; cyc = 0; finished = 0;
      etu_prev = 0; busy_prev = busy_o; valid_prev = 0; ready_prev = byte_ready_o;
      last_bit = bit_o;
      while (!finished && cyc < 8000) begin
         @(negedge clk);
         cyc++;
         if (valid_prev && ready_prev) acc++;
         if (etu_prev && busy_prev) begin
            got[got_n] = bit_o; got_n++;
         end else if (bit_o !== last_bit) stable_bad++;
         last_bit = bit_o;
         if (!busy_o && byte_ready_o) ready_bad++;
         if (done_o) begin
            dones++;
            if (busy_o) busy_bad++;
            finished = 1;
         end
         etu_en_i = !finished && (div % period == 0);
         div++;
         start_i = (cyc == restart_at);
         if (cyc == restart_at) len_i = 8'd3;
         byte_valid_i = (acc < len) && (stall_at < 0 || got_n >= stall_at);
         byte_data_i  = fb[acc < 16 ? acc : 0];
         etu_prev = etu_en_i; busy_prev = busy_o;
         valid_prev = byte_valid_i; ready_prev = byte_ready_o;
      end
      start_i = 1'b0; etu_en_i = 1'b0; byte_valid_i = 1'b0;
      chk(finished, "R7", {name, " frame ends with done"}, int'(finished), 1);
      @(negedge clk);
      chk(done_o === 1'b0 && busy_o === 1'b0, "R7", {name, " done lasts one cycle"}, int'(done_o), 0);
      chk(dones == 1 && busy_bad == 0, "R7", {name, " busy low at done"}, busy_bad, 0);
      chk(got_n == exp_n, (len == 0) ? "R6" : "R4", {name, " frame length"}, got_n, exp_n);
      cmp_range(0, 50, "R2", {name, " preamble and start marker"});
      cmp_range(50, exp_n - 43, (stall_at >= 0) ? "R10" : "R3", {name, " byte section"});
      cmp_range(exp_n - 43, exp_n, "R4", {name, " end marker and trailer"});
      chk(acc == len, (restart_at > 0) ? "R8" : "R11", {name, " bytes accepted"}, acc, len);
      chk(ready_bad == 0, "R9", {name, " ready only while busy"}, ready_bad, 0);
      chk(stable_bad == 0, "R5", {name, " line holds between etu pulses"}, stable_bad, 0);
      chk(bit_o === 1'b1, "R1", {name, " idle line high"}, int'(bit_o), 1);
   endtask

   initial begin
      int wd;
      wd = 0;
      while (wd < 150000) begin
         @(posedge clk);
         wd++;
      end
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", wd);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 16; i++) fb[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy_o === 1'b0 && done_o === 1'b0, "R1", "reset busy/done", int'(busy_o), 0);
      chk(byte_ready_o === 1'b0, "R1", "reset ready", int'(byte_ready_o), 0);
      chk(bit_o === 1'b1, "R1", "reset line level", int'(bit_o), 1);

      // R6: empty command
      run_frame(0, 4, -1, -1, 2, "empty");

      // R3: bit order patterns
      fb[0] = 8'hA5; fb[1] = 8'h01; fb[2] = 8'h80;
      run_frame(3, 4, -1, -1, 2, "order");

      // R3: data levels equal to neighbouring start/guard levels
      fb[0] = 8'h00; fb[1] = 8'hFF;
      run_frame(2, 3, -1, -1, 2, "flat");

      // R10: first byte withheld until 60 bits are out
      fb[0] = 8'h3C;
      run_frame(1, 4, 60, -1, 11, "stall");

      // R8: second start mid-frame
      fb[0] = 8'h12; fb[1] = 8'h34;
      run_frame(2, 4, -1, 20, 2, "restart");

      // R9: etu pulse every cycle
      fb[0] = 8'h5A; fb[1] = 8'hC3; fb[2] = 8'h0F; fb[3] = 8'hF0;
      run_frame(4, 1, -1, -1, 2, "backtoback");

      for (int r = 0; r < 6; r++) begin
         int l;
         l = $urandom_range(1, 8);
         for (int i = 0; i < 16; i++) fb[i] = 8'($urandom_range(0, 255));
         run_frame(l, $urandom_range(1, 5), -1, -1, 2, $sformatf("random%0d", r));
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule